// File: doc/BRIEF.md
# Cosine Soft Mute with Fixed Attenuator

This block sits in a stereo audio datapath and scales each incoming frame of signed samples. A frame arrives as one strobe carrying every channel at once. Two active-low controls shape the gain. The mute control does not cut the signal abruptly. It walks a shared gain index through a raised-cosine table, so the level falls smoothly to silence. When mute is released, the index walks back up through the same table. The attenuate control applies a fixed gain of about -12 dB on top of the mute gain.

Both controls are read only in a cycle that carries a frame. Changing them between frames has no effect on any sample. All channels use one gain index, so they ramp in lockstep. The index only moves when a frame is consumed. Each result appears two clock cycles after its frame, and the output holds its last value between results. The reset input is expected to be released synchronously to `clk` by the surrounding logic.

Top module: `soft_mute_atten`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_data is all zeros; after reset the gain index is 0 (full scale).
- R2: out_valid pulses exactly two clock cycles after each in_valid cycle and at no other time.
- R3: With mute_n and atten_n both high at a frame and the index at 0, each channel's output equals its input exactly (coefficient 32768 = 1.0 in unsigned Q1.15).
- R4: For a frame at gain index k, each channel output is (x*g + 16384) >>> 15 (arithmetic shift, round half up), where g = round(16384*(1+cos(pi*k/32))) for k in 0..31 and g = 0 for k = 32.
- R5: With mute_n held low at every frame, the index steps 0 to 32 one step at a time, so exactly 992 frames pass before the output is zero, and the output stays zero while mute persists.
- R6: With mute_n high at every frame, the index steps back down toward 0 through the same coefficients, 31 frames per index, including 31 frames at index 32 when leaving full mute.
- R7: When mute_n changes value between two frames in the middle of a ramp, the index is kept and the per-index frame count restarts, so the current index is used for 31 frames counted from the reversing frame.
- R8: When atten_n is low at a frame, the mute-scaled value is then multiplied by 8231 with the same rounding, and the result is saturated to the signed DW-bit range.
- R9: mute_n, atten_n and in_data are sampled only in cycles with in_valid high; between results out_data does not change.
- R10: All channels of a frame use the same gain, so equal inputs within a frame give equal outputs.
- R11: The gain index and its frame count do not advance in cycles without a frame, however long the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame strobe; one cycle per stereo frame |
| in_data | input | NCH*DW | Signed samples, channel c in bits [c*DW +: DW] |
| mute_n | input | 1 | Soft mute request, active low |
| atten_n | input | 1 | Fixed -12 dB attenuation request, active low |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_data | output | NCH*DW | Scaled signed samples, same channel packing |

## Verification
Every scaled frame is due two cycles after its strobe. The first register captures the mute product, and the second applies the attenuator. The bench stamps each predicted frame with the cycle it was driven in. It compares on the falling edge, where the result must sit exactly two cycles later. In every cycle without a result, the bench confirms the output held its value. The bench keeps its own gain index and count, updated only on driven frames, so ramp position, reversals and idle gaps all follow from the requirements rather than from the design.

// File: rtl/smatt_pkg.sv
package smatt_pkg;

  localparam int unsigned GAIN_W     = 16;
  localparam int unsigned GAIN_FRAC  = 15;
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned RAMP_STEPS = 32;

  typedef logic [IDX_W-1:0]  gidx_t;
  typedef logic [GAIN_W-1:0] gain_t;

  // index value that means silence
  localparam gidx_t IDX_FLOOR = gidx_t'(RAMP_STEPS);

  // about -12 dB in unsigned Q1.15
  localparam gain_t ATT_12DB = 16'd8231;

  // raised cosine: round(16384*(1+cos(pi*k/32))), zero at the floor
  function automatic gain_t ramp_gain(input gidx_t k);
    gain_t g;
    case (k)
      6'd0:  g = 16'd32768;
      6'd1:  g = 16'd32689;
      6'd2:  g = 16'd32453;
      6'd3:  g = 16'd32063;
      6'd4:  g = 16'd31521;
      6'd5:  g = 16'd30833;
      6'd6:  g = 16'd30007;
      6'd7:  g = 16'd29049;
      6'd8:  g = 16'd27969;
      6'd9:  g = 16'd26778;
      6'd10: g = 16'd25486;
      6'd11: g = 16'd24107;
      6'd12: g = 16'd22654;
      6'd13: g = 16'd21140;
      6'd14: g = 16'd19580;
      6'd15: g = 16'd17990;
      6'd16: g = 16'd16384;
      6'd17: g = 16'd14778;
      6'd18: g = 16'd13188;
      6'd19: g = 16'd11628;
      6'd20: g = 16'd10114;
      6'd21: g = 16'd8661;
      6'd22: g = 16'd7282;
      6'd23: g = 16'd5990;
      6'd24: g = 16'd4799;
      6'd25: g = 16'd3719;
      6'd26: g = 16'd2761;
      6'd27: g = 16'd1935;
      6'd28: g = 16'd1247;
      6'd29: g = 16'd705;
      6'd30: g = 16'd315;
      6'd31: g = 16'd79;
      default: g = 16'd0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/smatt_gain_seq.sv
module smatt_gain_seq
  import smatt_pkg::*;
#(
  parameter int unsigned HOLD  = 31,
  localparam int unsigned CNT_W = $clog2(HOLD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_en,
  input  logic             mute_req,
  output gidx_t            idx,
  output logic [CNT_W-1:0] cnt
);

  gidx_t            idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             at_end;
  logic [CNT_W-1:0] cnt_base;

  always_comb begin
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    at_end   = mute_req ? (idx_q == IDX_FLOOR) : (idx_q == '0);
    // a change of direction restarts the dwell on the current index
    cnt_base = (mute_req == dir_q) ? cnt_q : '0;
    if (frame_en) begin
      dir_d = mute_req;
      if (at_end) begin
        cnt_d = '0;
      end else if (cnt_base == CNT_W'(HOLD - 1)) begin
        cnt_d = '0;
        idx_d = mute_req ? (idx_q + IDX_W'(1)) : (idx_q - IDX_W'(1));
      end else begin
        cnt_d = cnt_base + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign idx = idx_q;
  assign cnt = cnt_q;

endmodule

// File: rtl/smatt_scale.sv
module smatt_scale #(
  parameter int unsigned DW   = 24,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 15
) (
  input  logic signed [DW-1:0] x,
  input  logic        [CW-1:0] coef,
  output logic signed [DW-1:0] y
);

  localparam int unsigned PW = DW + CW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);
  localparam logic signed [PW-1:0] HI   = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] LO   = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] xe, ce, prod, shf;

  always_comb begin
    xe   = {{(PW-DW){x[DW-1]}}, x};
    ce   = {{(PW-CW){1'b0}}, coef};
    prod = (xe * ce) + HALF;
    shf  = prod >>> FRAC;
    if (shf > HI) begin
      y = HI[DW-1:0];
    end else if (shf < LO) begin
      y = LO[DW-1:0];
    end else begin
      y = shf[DW-1:0];
    end
  end

endmodule

// File: rtl/soft_mute_atten.sv
module soft_mute_atten
  import smatt_pkg::*;
#(
  parameter int unsigned DW   = 24,
  parameter int unsigned NCH  = 2,
  parameter int unsigned HOLD = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_data,
  input  logic              mute_n,
  input  logic              atten_n,
  output logic              out_valid,
  output logic [NCH*DW-1:0] out_data
);

  localparam int unsigned BUS_W = NCH * DW;
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  gidx_t            gain_idx;
  logic [CNT_W-1:0] hold_cnt;
  gain_t            cur_gain;

  logic [BUS_W-1:0] mute_prod;
  logic [BUS_W-1:0] att_prod;

  logic             s1_valid_q, s1_valid_d;
  logic             s1_att_q,   s1_att_d;
  logic [BUS_W-1:0] s1_data_q,  s1_data_d;
  logic             o_valid_q,  o_valid_d;
  logic [BUS_W-1:0] o_data_q,   o_data_d;

  smatt_gain_seq #(.HOLD(HOLD)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_en (in_valid),
    .mute_req (~mute_n),
    .idx      (gain_idx),
    .cnt      (hold_cnt)
  );

  assign cur_gain = ramp_gain(gain_idx);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smatt_scale #(.DW(DW), .CW(GAIN_W), .FRAC(GAIN_FRAC)) u_mute_mul (
      .x    (in_data[c*DW +: DW]),
      .coef (cur_gain),
      .y    (mute_prod[c*DW +: DW])
    );
    smatt_scale #(.DW(DW), .CW(GAIN_W), .FRAC(GAIN_FRAC)) u_att_mul (
      .x    (s1_data_q[c*DW +: DW]),
      .coef (ATT_12DB),
      .y    (att_prod[c*DW +: DW])
    );
  end

  // stage 1: mute gain, attenuation request captured with the frame
  always_comb begin
    s1_valid_d = in_valid;
    s1_att_d   = s1_att_q;
    s1_data_d  = s1_data_q;
    if (in_valid) begin
      s1_att_d  = ~atten_n;
      s1_data_d = mute_prod;
    end
  end

  // stage 2: optional fixed attenuation
  always_comb begin
    o_valid_d = s1_valid_q;
    o_data_d  = o_data_q;
    if (s1_valid_q) begin
      o_data_d = s1_att_q ? att_prod : s1_data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_att_q   <= 1'b0;
      s1_data_q  <= '0;
      o_valid_q  <= 1'b0;
      o_data_q   <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_att_q   <= s1_att_d;
      s1_data_q  <= s1_data_d;
      o_valid_q  <= o_valid_d;
      o_data_q   <= o_data_d;
    end
  end

  assign out_valid = o_valid_q;
  assign out_data  = o_data_q;

endmodule

// File: rtl/smatt_chk.sv
module smatt_chk #(
  parameter int unsigned DW    = 24,
  parameter int unsigned NCH   = 2,
  parameter int unsigned HOLD  = 31,
  localparam int unsigned CNT_W = $clog2(HOLD + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              mute_n,
  input logic              out_valid,
  input logic [NCH*DW-1:0] out_data,
  input logic [5:0]        idx,
  input logic [CNT_W-1:0]  cnt
);

  logic v1_q, v2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v2_q);

  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= 6'd32);

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == $past(idx)) || (idx == $past(idx) + 6'd1) || (idx + 6'd1 == $past(idx)));

  p_rise_needs_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > $past(idx)) |-> !$past(mute_n));

  p_dwell_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(HOLD));

  p_idle_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(idx) && $stable(cnt)));

  p_hold_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind soft_mute_atten smatt_chk #(.DW(DW), .NCH(NCH), .HOLD(HOLD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mute_n    (mute_n),
  .out_valid (out_valid),
  .out_data  (out_data),
  .idx       (gain_idx),
  .cnt       (hold_cnt)
);

// File: tb/soft_mute_atten_tb.sv
module soft_mute_atten_tb;

  localparam int DW   = 24;
  localparam int NCH  = 2;
  localparam int HOLD = 31;
  localparam longint WD_LIMIT = 64'd20 * 64'd150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [NCH*DW-1:0] in_data;
  logic              mute_n;
  logic              atten_n;
  logic              out_valid;
  logic [NCH*DW-1:0] out_data;

  soft_mute_atten #(.DW(DW), .NCH(NCH), .HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .mute_n(mute_n), .atten_n(atten_n), .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  typedef struct {
    longint e0;
    longint e1;
    int     cyc;
    string  tag;
    bit     same;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int m_idx = 0;
  int m_cnt = 0;
  bit m_dir = 0;
  logic [NCH*DW-1:0] last_out;
  logic signed [DW-1:0] o0, o1;
  assign o0 = out_data[DW-1:0];
  assign o1 = out_data[2*DW-1:DW];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic longint bgain(input int k);
    if (k >= 32) return 0;
    return longint'($rtoi(16384.0 * (1.0 + $cos(3.14159265358979 * k / 32.0)) + 0.5));
  endfunction

  function automatic longint bscale(input longint x, input longint g);
    longint p, hi, lo;
    hi = (64'sd1 <<< (DW - 1)) - 1;
    lo = -(64'sd1 <<< (DW - 1));
    p = (x * g + 16384) >>> 15;
    if (p > hi) p = hi;
    if (p < lo) p = lo;
    return p;
  endfunction

  function automatic longint rnd_sample();
    logic signed [DW-1:0] t;
    t = DW'($urandom);
    return longint'(t);
  endfunction

  // checks on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n !== 1'b1) begin
      chk(out_valid == 1'b0 && out_data == '0, "R1", longint'(out_valid), 0);
    end else if (out_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2 spurious", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.cyc + 2, "R2 latency", cyc, e.cyc + 2);
        chk(longint'(o0) == e.e0, e.tag, longint'(o0), e.e0);
        chk(longint'(o1) == e.e1, e.tag, longint'(o1), e.e1);
        if (e.same) chk(o0 == o1, "R10", longint'(o1), longint'(o0));
      end
    end else begin
      chk(out_data == last_out, "R9 hold", longint'(o0), longint'($signed(last_out[DW-1:0])));
    end
    last_out = out_data;
  end

  task automatic send(input bit m_n, input bit a_n, input longint l, input longint r, input string tag);
    exp_t e;
    longint g;
    bit m, at_end;
    int base;
    @(posedge clk);
    #2;
    mute_n   = m_n;
    atten_n  = a_n;
    in_data  = {DW'(r), DW'(l)};
    in_valid = 1'b1;
    g = bgain(m_idx);
    e.e0 = bscale(l, g);
    e.e1 = bscale(r, g);
    if (!a_n) begin
      e.e0 = bscale(e.e0, 8231);
      e.e1 = bscale(e.e1, 8231);
    end
    e.cyc  = cyc;
    e.same = (l == r);
    e.tag  = (m_idx == 32 && !m_n) ? "R5" : tag;
    q.push_back(e);
    m = !m_n;
    at_end = m ? (m_idx == 32) : (m_idx == 0);
    base = (m == m_dir) ? m_cnt : 0;
    if (at_end) m_cnt = 0;
    else if (base == HOLD - 1) begin
      m_cnt = 0;
      m_idx = m ? m_idx + 1 : m_idx - 1;
    end else m_cnt = base + 1;
    m_dir = m;
  endtask

  // idle cycles: controls and data wiggle, none of it may matter (R9)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      in_valid = 1'b0;
      in_data  = {DW'($urandom), DW'($urandom)};
      mute_n   = 1'($urandom);
      atten_n  = 1'($urandom);
    end
  endtask

  task automatic run(input int n, input bit m_n, input int amode, input int maxgap, input string tag);
    for (int i = 0; i < n; i++) begin
      longint l, r;
      bit a_n;
      a_n = (amode == 0) ? 1'b1 : (amode == 1) ? 1'b0 : 1'($urandom);
      l = rnd_sample();
      r = (i % 7 == 0) ? l : rnd_sample();
      send(m_n, a_n, l, r, tag);
      if (maxgap > 0) idle(int'($urandom % (maxgap + 1)));
      else begin
        @(posedge clk);
        #2;
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    #(WD_LIMIT);
    bad++;
    total++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint mx, mn;
    void'($urandom(32'h5eed_0042));
    mx = (64'sd1 <<< (DW - 1)) - 1;
    mn = -(64'sd1 <<< (DW - 1));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; mute_n = 1'b1; atten_n = 1'b1;
    last_out = '0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(4);

    run(40, 1'b1, 0, 2, "R3");                  // R3 unity pass-through
    run(40, 1'b1, 2, 2, "R8");                  // R8 random attenuation
    send(1'b1, 1'b0, mx, mn, "R8"); idle(1);    // R8 extremes attenuated
    send(1'b1, 1'b1, mn, mx, "R3"); idle(1);    // R3 extremes at unity
    send(1'b1, 1'b0, mn, mn, "R8"); idle(2);

    run(1000, 1'b0, 0, 1, "R4");                // R4 ramp down, R5 floor
    run(40, 1'b0, 2, 1, "R5");                  // R5 stays silent
    run(1030, 1'b1, 0, 1, "R6");                // R6 ramp back up
    run(300, 1'b0, 0, 1, "R7");                 // R7 reversals mid ramp
    run(100, 1'b1, 2, 1, "R7");
    run(45, 1'b0, 0, 0, "R7");
    run(60, 1'b1, 0, 0, "R7");
    run(25, 1'b0, 0, 1, "R11");                 // R11 long gap mid ramp
    idle(300);
    run(40, 1'b0, 0, 0, "R11");
    idle(200);
    run(700, 1'b1, 2, 1, "R6");
    run(20, 1'b1, 0, 0, "R3");
    idle(6);
    chk(q.size() == 0, "R2 drained", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule